// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a register of `WIDTH` stages (eight by default) that can keep its contents, move them one place toward the high stage, move them one place toward the low stage, or capture a whole word from its parallel port. The parallel port is meant to be shared: the same pins carry the stage values out and bring the capture word in. On chip each pin is modelled as three signals: an input `pin_in`, an output `pin_out` that always carries the stage value, and a common drive enable `pin_oe`. A wrapper at the pad ring may combine them into a real bidirectional pin.

The operating mode is a small decoded state held by the `mode_sel` selects. The four named states are KEEP (00), TO_HI (01), TO_LO (10) and CAPTURE (11). On each rising clock edge the register takes the transition named by the current state: KEEP leaves the stages unchanged; TO_HI moves every stage into the next higher one and brings `ser_lo` into stage 0; TO_LO moves every stage into the next lower one and brings `ser_hi` into the top stage; CAPTURE loads `pin_in`. An active-low reset clears every stage at once, without waiting for a clock, and overrides all of these transitions.

The parallel port is driven only when both active-low enables are low and the state is not CAPTURE, so the pins are released for an external driver whenever a capture is selected. Turning the drivers off does not pause the register. Stage 0 and the top stage also appear on `tap_lo` and `tap_hi`, which are never released. Feeding `tap_hi` of one register into `ser_lo` of the next chains registers into longer words.

Top module: `ushift_reg`

## Requirements
- R1: With `mode_sel` = 00 (KEEP), a rising clock edge leaves all stages unchanged.
- R2: With `mode_sel` = 01 (TO_HI), a rising edge puts `ser_lo` into stage 0 and the old value of each stage n into stage n+1. Stage n appears on `pin_out[n]`.
- R3: With `mode_sel` = 10 (TO_LO), a rising edge puts `ser_hi` into the top stage and the old value of each stage n into stage n-1.
- R4: With `mode_sel` = 11 (CAPTURE), a rising edge loads `pin_in` into the stages, bit n into stage n.
- R5: When `rst_n` goes low, all stages read zero at once, before any clock edge.
- R6: While `rst_n` stays low, the stages remain zero under a running clock, whatever the selects (including CAPTURE) and the data inputs are.
- R7: `pin_oe` is 1 exactly when `oe_a_n` and `oe_b_n` are both 0 and `mode_sel` is not 11. It is 0 otherwise.
- R8: `pin_out` carries the stage values whatever the value of `pin_oe`. KEEP, TO_HI, TO_LO and CAPTURE act the same whether the drivers are enabled or not.
- R9: `tap_lo` always equals stage 0 and `tap_hi` always equals the top stage. Neither is ever released.
- R10: Two registers with `tap_hi` of the lower one wired to `ser_lo` of the upper one behave as a single register of twice the width in TO_HI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | Mode: 00 KEEP, 01 TO_HI, 10 TO_LO, 11 CAPTURE |
| ser_lo | input | 1 | Serial bit entering stage 0 in TO_HI |
| ser_hi | input | 1 | Serial bit entering the top stage in TO_LO |
| oe_a_n | input | 1 | Port drive enable, active low |
| oe_b_n | input | 1 | Second port drive enable, active low |
| pin_in | input | WIDTH | Parallel port, inbound side |
| pin_out | output | WIDTH | Parallel port, outbound side (stage values) |
| pin_oe | output | 1 | Parallel port drive enable |
| tap_lo | output | 1 | Stage 0, always driven |
| tap_hi | output | 1 | Top stage, always driven |

## Verification
A wrong stage value appears on `pin_out` and on the taps in the same cycle it is registered, so a wrong next-value choice shows one edge after the mode is applied, whether or not the drivers are enabled. An error in the drive-enable decode shows at once on `pin_oe`, because that output is combinational from the selects and enables. A broken clear shows within a fraction of a cycle after `rst_n` falls, or on the first edge taken while it is held. A fault in how a serial input enters a stage or how a bit reaches a tap shows in the chained pair. There, the upper register's contents drift from a wide reference model on the edge after the faulty bit position is used.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    typedef enum logic [1:0] {
        OP_KEEP    = 2'b00,
        OP_TO_HI   = 2'b01,
        OP_TO_LO   = 2'b10,
        OP_CAPTURE = 2'b11
    } op_e;

endpackage

// File: rtl/ushift_ctrl.sv
module ushift_ctrl
    import ushift_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    output op_e        op,
    output logic       drive_en
);

    // Mode decode: one named state per select code.
    always_comb begin
        unique case (mode_sel)
            2'b00:   op = OP_KEEP;
            2'b01:   op = OP_TO_HI;
            2'b10:   op = OP_TO_LO;
            default: op = OP_CAPTURE;
        endcase
    end

    // Port drivers released for capture or for either enable inactive.
    always_comb begin
        drive_en = 1'b0;
        unique case (op)
            OP_KEEP, OP_TO_HI, OP_TO_LO: drive_en = ~oe_a_n & ~oe_b_n;
            OP_CAPTURE:                  drive_en = 1'b0;
        endcase
    end

    assert_release_on_capture_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |-> !drive_en);

    assert_release_on_enable_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n) |-> !drive_en);

    assert_drive_when_allowed_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!oe_a_n && !oe_b_n && mode_sel != 2'b11) |-> drive_en);

endmodule

// File: rtl/ushift_core.sv
module ushift_core
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic             ser_lo,
    input  logic             ser_hi,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stage_q
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] stage_d;
    logic [WIDTH-1:0] below;   // value of the neighbour one place lower
    logic [WIDTH-1:0] above;   // value of the neighbour one place higher

    assign below = {stage_q[TOP-1:0], ser_lo};
    assign above = {ser_hi, stage_q[TOP:1]};

    // Per-stage next-value selection.
    for (genvar n = 0; n < WIDTH; n++) begin : g_stage
        always_comb begin
            unique case (op)
                OP_KEEP:    stage_d[n] = stage_q[n];
                OP_TO_HI:   stage_d[n] = below[n];
                OP_TO_LO:   stage_d[n] = above[n];
                OP_CAPTURE: stage_d[n] = par_in[n];
            endcase
        end
    end

    // State register with asynchronous clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assert_keep_stable_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (op == OP_KEEP) |=> $stable(stage_q));

    assert_to_hi_entry_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (op == OP_TO_HI) |=> (stage_q[0] == $past(ser_lo)
                              && stage_q[TOP:1] == $past(stage_q[TOP-1:0])));

    assert_to_lo_entry_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (op == OP_TO_LO) |=> (stage_q[TOP] == $past(ser_hi)
                              && stage_q[TOP-1:0] == $past(stage_q[TOP:1])));

    assert_capture_word_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (op == OP_CAPTURE) |=> (stage_q == $past(par_in)));

endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             ser_lo,
    input  logic             ser_hi,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic             pin_oe,
    output logic             tap_lo,
    output logic             tap_hi
);

    localparam int TOP = WIDTH - 1;

    op_e              op;
    logic [WIDTH-1:0] stage_q;

    ushift_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .op       (op),
        .drive_en (pin_oe)
    );

    ushift_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .ser_lo  (ser_lo),
        .ser_hi  (ser_hi),
        .par_in  (pin_in),
        .stage_q (stage_q)
    );

    assign pin_out = stage_q;
    assign tap_lo  = stage_q[0];
    assign tap_hi  = stage_q[TOP];

    assert_taps_follow_port_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (tap_lo == pin_out[0]) && (tap_hi == pin_out[TOP]));

endmodule

// File: tb/ushift_reg_test.sv
`timescale 1ns/100ps
module ushift_reg_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [1:0]   mode_sel = 2'b00;
    logic         ser_lo = 1'b0, ser_hi = 1'b0;
    logic         oe_a_n = 1'b0, oe_b_n = 1'b0;
    logic [W-1:0] pin_in = '0, pin_in_hi = '0;
    logic [W-1:0] pin_out, pin_out_hi;
    logic         pin_oe, pin_oe_hi, tap_lo, tap_hi, tap_lo_hi, tap_hi_hi;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ushift_reg #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .ser_lo(ser_lo), .ser_hi(ser_hi),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .tap_lo(tap_lo), .tap_hi(tap_hi)
    );

    // Upper half of a chained pair: fed from the top tap of uut.
    ushift_reg #(.WIDTH(W)) uut_hi (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .ser_lo(tap_hi), .ser_hi(1'b0),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .pin_in(pin_in_hi), .pin_out(pin_out_hi), .pin_oe(pin_oe_hi),
        .tap_lo(tap_lo_hi), .tap_hi(tap_hi_hi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // {mode[1:0], ser_lo, ser_hi, oe_a_n, oe_b_n, pin_in[7:0], exp_q[7:0], exp_oe}
    localparam int NV = 11;
    localparam logic [22:0] VEC [NV] = '{
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0},  // R4 capture
        {2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'hA5, 1'b1},  // R1 keep
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h4B, 1'b1},  // R2 to high
        {2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h25, 1'b1},  // R3 to low, 0 in
        {2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h92, 1'b0},  // R3 R8 drivers off
        {2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h24, 1'b0},  // R2 R8 drivers off
        {2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 8'h3C, 1'b0},  // R4 R8
        {2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h3C, 1'b0},  // R1 R8
        {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h78, 1'b1},  // R2
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 8'h81, 1'b0},  // R4
        {2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h40, 1'b1}   // R3
    };

    initial begin
        #150000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] model;
        logic [15:0]    pattern;

        // Reset state
        #1 rst_n = 1'b0;
        #0.5;
        check("R5 reset clears port", {24'd0, pin_out}, 32'h0);
        check("R9 reset taps", {30'd0, tap_lo, tap_hi}, 32'h0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table
        for (int v = 0; v < NV; v++) begin
            {mode_sel, ser_lo, ser_hi, oe_a_n, oe_b_n, pin_in} = VEC[v][22:9];
            #0.5;
            check($sformatf("R7 drive enable vec %0d", v), {31'd0, pin_oe}, {31'd0, VEC[v][0]});
            @(negedge clk);
            check($sformatf("R1-4 R8 stages vec %0d", v), {24'd0, pin_out}, {24'd0, VEC[v][8:1]});
            check($sformatf("R9 taps vec %0d", v), {30'd0, tap_lo, tap_hi},
                  {30'd0, VEC[v][1], VEC[v][8]});
        end

        // R10: chained pair against a double-width model
        mode_sel = 2'b11; oe_a_n = 1'b0; oe_b_n = 1'b0;
        pin_in = 8'h5A; pin_in_hi = 8'hC3;
        @(negedge clk);
        model = 16'hC35A;
        check("R10 chain capture", {16'd0, pin_out_hi, pin_out}, {16'd0, model});
        pattern = 16'hB1E4;
        mode_sel = 2'b01;
        for (int k = 0; k < 16; k++) begin
            ser_lo = pattern[k];
            @(negedge clk);
            model = {model[2*W-2:0], pattern[k]};
            check($sformatf("R10 chain step %0d", k), {16'd0, pin_out_hi, pin_out}, {16'd0, model});
        end

        // R5: clear in the middle of a cycle, no edge needed
        mode_sel = 2'b11; pin_in = 8'h7E;
        @(negedge clk);
        check("R4 capture before clear", {24'd0, pin_out}, 32'h7E);
        @(posedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        check("R5 mid-cycle clear", {24'd0, pin_out}, 32'h0);
        check("R5 mid-cycle clear upper", {24'd0, pin_out_hi}, 32'h0);
        check("R9 taps after clear", {30'd0, tap_lo, tap_hi}, 32'h0);

        // R6: held clear with capture selected and clock running
        pin_in = 8'hFF; pin_in_hi = 8'hFF; mode_sel = 2'b11;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check($sformatf("R6 held clear cycle %0d", c), {24'd0, pin_out}, 32'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 capture after release", {24'd0, pin_out}, 32'hFF);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule